// File: doc/BRIEF.md
# Quarter-Row Stream Parser

This block turns a serial pixel-readout stream into one record per quarter row. Stream words of 64 bits arrive on a valid/ready input. Bit 63 of each word is a start marker that has already been handled upstream, so the block ignores it. The 63 remaining payload bits are appended to a window that holds three words. A bit pointer walks through that window. Fields are read most-significant first, starting at bit 62 of the oldest word.

Each record holds the fields below, in this order:
- an optional 6-bit column address
- an is-last flag and an is-neighbor flag
- an optional 8-bit quarter-row address
- a variable-length encoded hitmap
- one 4-bit time-over-threshold value per hit

Two flags decide whether the optional fields are present. The previous record's is-last flag decides whether the column is present. The current record's is-neighbor flag decides whether the row is present. The block works out the hitmap length itself and counts its hits, which sizes the time-over-threshold field. It then emits a registered record on a valid/ready output.

A six-state consume machine does the work. One state loads words into the window, four states parse the record, and one state presents it. The machine stalls whenever the window lacks data or the consumer holds the output.

Top module: `qrow_parser`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: When the previous record's is-last flag is 1, the record starts with a 6-bit column address, and the first record after reset always carries one. When that flag is 0, no column field is present and the previous column is reported again.
- R3: When is-neighbor is 0, an 8-bit row address follows the two flags. When it is 1, no row field is present and the row is the previous row plus one, modulo 256.
- R4: Field order is: column (when present), is-last, is-neighbor, row (when present), hitmap, then the time-over-threshold values. Each field is most-significant bit first. Stream bit order is bit 62 down to bit 0 of each word, oldest word first. Bit 63 has no effect.
- R5: The hitmap is a pre-order walk of a binary tree over 16 pixels. The levels, from the top, are rows, halves, pairs and pixels, and the lower-index child is visited first. Each visited node emits a code: "11" means both children are present, "10" means only the lower child, and "0" means only the upper child. Pixel index is row*8 + half*4 + pair*2 + bit, and out_hitmap bit i is pixel i.
- R6: out_hits equals the number of set hitmap bits. The k-th value in the stream, in increasing pixel order, appears at out_tot[4k+3:4k]. Bits above 4*out_hits are 0.
- R7: A record is parsed only when all three window words are loaded. While fewer words have arrived, out_valid stays 0, and parsing resumes once words arrive.
- R8: While out_valid is 1 and out_ready is 0, out_valid and all record fields hold their values.
- R9: The output handshake and the next rise of out_valid are at least 6 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream word offered |
| in_ready | output | 1 | Block takes the offered word |
| in_data | input | 64 | Stream word; bit 63 ignored |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Consumer accepts the record |
| out_col | output | 6 | Column address |
| out_row | output | 8 | Quarter-row address |
| out_hitmap | output | 16 | Decoded hitmap, bit i = pixel i |
| out_hits | output | 5 | Number of hits (0 to 16) |
| out_tot | output | 64 | Packed 4-bit time-over-threshold values |

## Verification
The stream is first built from all sixteen single-pixel hitmaps. Each of these uses only one branch at every tree level, so they separate the "0" code from the "10" code and expose any swapped pixel order. The full hitmap follows, which exercises the longest code and the widest time-over-threshold field. A stride sweep through 1700 hitmap values then mixes branch shapes and lets records straddle word boundaries at many pointer offsets.

Across the whole run, the is-last and is-neighbor flags follow different periods, so every combination of column and row elision occurs. Gaps in the input and stalls on the output show whether the window and the output register hold their state.

// File: rtl/qrp_pkg.sv
package qrp_pkg;
  localparam int PKT_W    = 64;
  localparam int PAY_W    = PKT_W - 1;
  localparam int WIN_PKTS = 3;
  localparam int WIN_W    = PAY_W * WIN_PKTS;
  localparam int COL_W    = 6;
  localparam int ROW_W    = 8;
  localparam int TOT_W    = 4;
  localparam int PIX_N    = 16;
  localparam int CODE_MAX = 2 * (PIX_N - 1);
  localparam int HDR_W    = COL_W + 2 + ROW_W;
  localparam int TOTS_W   = TOT_W * PIX_N;
  localparam int VIEW_W   = TOTS_W;
  localparam int PTR_W    = $clog2(WIN_W + 1);
  localparam int HIT_W    = $clog2(PIX_N + 1);
  localparam int LEN_W    = $clog2(CODE_MAX + 1);

  typedef enum logic [2:0] {ST_FILL, ST_HDR, ST_MAP, ST_TOT, ST_PACK, ST_OUT} st_t;

  typedef struct packed {
    logic [1:0] kid;   // kid[0] lower child, kid[1] upper child
    logic [1:0] len;
  } node_t;

  typedef struct packed {
    logic [PIX_N-1:0] map;
    logic [LEN_W-1:0] len;
  } map_t;

  typedef struct packed {
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;
    logic             last;
    logic [LEN_W-1:0] len;
  } hdr_t;

  // one tree node: "0" upper only, "10" lower only, "11" both
  function automatic node_t node_code(input logic [1:0] b);
    node_t n;
    if (!b[1]) begin
      n.kid = 2'b10;
      n.len = 2'd1;
    end else begin
      n.kid = {b[0], 1'b1};
      n.len = 2'd2;
    end
    return n;
  endfunction

  // pre-order walk: rows, halves, pairs, pixels
  function automatic map_t decode_map(input logic [CODE_MAX-1:0] code);
    map_t m;
    node_t nt, nr, nh, nq;
    logic [CODE_MAX-1:0] sh;
    int p;
    m  = '0;
    nt = node_code(code[CODE_MAX-1 -: 2]);
    p  = int'(nt.len);
    for (int r = 0; r < 2; r++) if (nt.kid[r]) begin
      sh = code << p;
      nr = node_code(sh[CODE_MAX-1 -: 2]);
      p += int'(nr.len);
      for (int h = 0; h < 2; h++) if (nr.kid[h]) begin
        sh = code << p;
        nh = node_code(sh[CODE_MAX-1 -: 2]);
        p += int'(nh.len);
        for (int q = 0; q < 2; q++) if (nh.kid[q]) begin
          sh = code << p;
          nq = node_code(sh[CODE_MAX-1 -: 2]);
          p += int'(nq.len);
          for (int b = 0; b < 2; b++)
            if (nq.kid[b]) m.map[r*8 + h*4 + q*2 + b] = 1'b1;
        end
      end
    end
    m.len = LEN_W'(p);
    return m;
  endfunction

  function automatic hdr_t parse_hdr(input logic [HDR_W-1:0] v, input logic prev_last,
                                     input logic [COL_W-1:0] prev_col,
                                     input logic [ROW_W-1:0] prev_row);
    hdr_t h;
    logic [HDR_W-1:0] s;
    logic nbr;
    int p;
    p = 0;
    if (prev_last) begin
      h.col = v[HDR_W-1 -: COL_W];
      p = COL_W;
    end else h.col = prev_col;
    s      = v << p;
    h.last = s[HDR_W-1];
    nbr    = s[HDR_W-2];
    p += 2;
    if (nbr) h.row = prev_row + ROW_W'(1);
    else begin
      s = v << p;
      h.row = s[HDR_W-1 -: ROW_W];
      p += ROW_W;
    end
    h.len = LEN_W'(p);
    return h;
  endfunction

  // raw is top-aligned in stream order; value k goes to bits [4k+3:4k]
  function automatic logic [TOTS_W-1:0] pack_tot(input logic [TOTS_W-1:0] raw,
                                                 input logic [HIT_W-1:0] hits);
    logic [TOTS_W-1:0] t;
    t = '0;
    for (int k = 0; k < PIX_N; k++)
      if (k < int'(hits)) t[k*TOT_W +: TOT_W] = raw[TOTS_W-1-k*TOT_W -: TOT_W];
    return t;
  endfunction
endpackage

// File: rtl/qrp_window.sv
module qrp_window
  import qrp_pkg::*;
#(
  parameter int P_PAY  = PAY_W,
  parameter int P_PKTS = WIN_PKTS,
  parameter int P_VIEW = VIEW_W,
  parameter int P_PTR  = PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  logic              in_valid,
  input  logic [P_PAY:0]    in_data,
  output logic              in_ready,
  input  logic              adv_en,
  input  logic [P_PTR-1:0]  adv_bits,
  output logic              parse_ok,
  output logic [P_VIEW-1:0] view
);
  localparam int W_W   = P_PAY * P_PKTS;
  localparam int CNT_W = $clog2(P_PKTS + 1);

  logic [W_W-1:0]   win;
  logic [W_W-1:0]   shw;
  logic [CNT_W-1:0] cnt;
  logic [P_PTR-1:0] ptr;
  logic             need_pkt, take;
  logic             sob_unused;

  assign sob_unused = in_data[P_PAY];
  assign need_pkt   = (cnt < CNT_W'(P_PKTS)) || (ptr >= P_PTR'(P_PAY));
  assign in_ready   = fill_en && need_pkt;
  assign take       = in_ready && in_valid;
  assign parse_ok   = (cnt == CNT_W'(P_PKTS)) && (ptr < P_PTR'(P_PAY));
  assign shw        = win << ptr;
  assign view       = shw[W_W-1 -: P_VIEW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win <= '0;
      cnt <= '0;
      ptr <= '0;
    end else if (take) begin
      win <= {win[W_W-P_PAY-1:0], in_data[P_PAY-1:0]};
      if (cnt == CNT_W'(P_PKTS)) ptr <= ptr - P_PTR'(P_PAY);
      else                       cnt <= cnt + CNT_W'(1);
    end else if (adv_en) begin
      ptr <= ptr + adv_bits;
    end
  end

  // R7
  ptr_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en |-> (ptr < P_PTR'(W_W - P_PAY)));
  // R7
  parse_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en |-> (cnt == CNT_W'(P_PKTS)));
endmodule

// File: rtl/qrp_mapdec.sv
module qrp_mapdec
  import qrp_pkg::*;
(
  input  logic [CODE_MAX-1:0] code,
  output logic [PIX_N-1:0]    map,
  output logic [LEN_W-1:0]    len,
  output logic [HIT_W-1:0]    hits
);
  map_t d;
  always_comb begin
    d    = decode_map(code);
    map  = d.map;
    len  = d.len;
    hits = HIT_W'($countones(d.map));
  end
endmodule

// File: rtl/qrow_parser.sv
module qrow_parser
  import qrp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PKT_W-1:0]  in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [COL_W-1:0]  out_col,
  output logic [ROW_W-1:0]  out_row,
  output logic [PIX_N-1:0]  out_hitmap,
  output logic [HIT_W-1:0]  out_hits,
  output logic [TOTS_W-1:0] out_tot
);
  st_t               state;
  logic              fill_en, adv_en, parse_ok;
  logic [PTR_W-1:0]  adv_bits;
  logic [VIEW_W-1:0] view;
  hdr_t              hdr;
  logic [PIX_N-1:0]  dmap;
  logic [LEN_W-1:0]  dlen;
  logic [HIT_W-1:0]  dhits;
  logic              prev_last;
  logic [COL_W-1:0]  prev_col;
  logic [ROW_W-1:0]  prev_row;
  logic [PIX_N-1:0]  cur_map;
  logic [HIT_W-1:0]  cur_hits;
  logic [TOTS_W-1:0] raw_tot;
  logic [2:0]        gap;

  qrp_window i_win (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .adv_en(adv_en), .adv_bits(adv_bits), .parse_ok(parse_ok), .view(view)
  );

  qrp_mapdec i_dec (
    .code(view[VIEW_W-1 -: CODE_MAX]), .map(dmap), .len(dlen), .hits(dhits)
  );

  always_comb begin
    fill_en  = (state == ST_FILL);
    adv_en   = 1'b0;
    adv_bits = '0;
    hdr      = parse_hdr(view[VIEW_W-1 -: HDR_W], prev_last, prev_col, prev_row);
    case (state)
      ST_HDR: begin adv_en = 1'b1; adv_bits = PTR_W'(hdr.len); end
      ST_MAP: begin adv_en = 1'b1; adv_bits = PTR_W'(dlen); end
      ST_TOT: begin adv_en = 1'b1; adv_bits = PTR_W'(cur_hits) << 2; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_FILL;
      prev_last  <= 1'b1;
      prev_col   <= '0;
      prev_row   <= '0;
      cur_map    <= '0;
      cur_hits   <= '0;
      raw_tot    <= '0;
      out_valid  <= 1'b0;
      out_col    <= '0;
      out_row    <= '0;
      out_hitmap <= '0;
      out_hits   <= '0;
      out_tot    <= '0;
    end else begin
      case (state)
        ST_FILL: if (parse_ok) state <= ST_HDR;
        ST_HDR: begin
          prev_col  <= hdr.col;
          prev_row  <= hdr.row;
          prev_last <= hdr.last;
          state     <= ST_MAP;
        end
        ST_MAP: begin
          cur_map  <= dmap;
          cur_hits <= dhits;
          state    <= ST_TOT;
        end
        ST_TOT: begin
          raw_tot <= view;
          state   <= ST_PACK;
        end
        ST_PACK: begin
          out_col    <= prev_col;
          out_row    <= prev_row;
          out_hitmap <= cur_map;
          out_hits   <= cur_hits;
          out_tot    <= pack_tot(raw_tot, cur_hits);
          out_valid  <= 1'b1;
          state      <= ST_OUT;
        end
        ST_OUT: if (out_ready) begin
          out_valid <= 1'b0;
          state     <= ST_FILL;
        end
        default: state <= ST_FILL;
      endcase
    end
  end

  // cycles since the last output handshake, saturating
  always_ff @(posedge clk) begin
    if (!rst_n)                       gap <= 3'd7;
    else if (out_valid && out_ready)  gap <= 3'd1;
    else if (gap != 3'd7)             gap <= gap + 3'd1;
  end

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_col) && $stable(out_row)
      && $stable(out_hitmap) && $stable(out_hits) && $stable(out_tot)));
  // R9
  rec_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (gap >= 3'd6));
  // R5
  map_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_hitmap != '0));
  // R6
  tot_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_tot >> {out_hits, 2'b00}) == '0));
  // R7
  no_input_while_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
endmodule

// File: tb/test_qrow_parser.sv
module test_qrow_parser;
  import qrp_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NSINGLE    = 16;
  localparam int NSWEEP     = 1700;
  localparam int NREC       = NSINGLE + 1 + NSWEEP;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [63:0] in_data = '0;
  logic in_ready, out_valid;
  logic [5:0] out_col;
  logic [7:0] out_row;
  logic [15:0] out_hitmap;
  logic [4:0] out_hits;
  logic [63:0] out_tot;

  qrow_parser i_qrow_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_col(out_col), .out_row(out_row),
    .out_hitmap(out_hitmap), .out_hits(out_hits), .out_tot(out_tot)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, npk = 0;
  bit bq[$];
  logic [5:0]  e_col [NREC];
  logic [7:0]  e_row [NREC];
  logic [15:0] e_map [NREC];
  logic [4:0]  e_hits[NREC];
  logic [63:0] e_tot [NREC];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_bits(input logic [7:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bq.push_back(v[i]);
  endtask

  task automatic push_node(input bit lo, input bit hi);
    if (lo && hi) push_bits(8'd3, 2);
    else if (lo)  push_bits(8'd2, 2);
    else          push_bits(8'd0, 1);
  endtask

  // R5 encoder over pixel ranges, lower range first
  task automatic push_map(input logic [15:0] hm);
    push_node(hm[7:0] != 0, hm[15:8] != 0);
    for (int r = 0; r < 2; r++) begin
      logic [7:0] s8 = hm[r*8 +: 8];
      if (s8 != 0) begin
        push_node(s8[3:0] != 0, s8[7:4] != 0);
        for (int h = 0; h < 2; h++) begin
          logic [3:0] s4 = s8[h*4 +: 4];
          if (s4 != 0) begin
            push_node(s4[1:0] != 0, s4[3:2] != 0);
            for (int q = 0; q < 2; q++) begin
              logic [1:0] s2 = s4[q*2 +: 2];
              if (s2 != 0) push_node(s2[0], s2[1]);
            end
          end
        end
      end
    end
  endtask

  function automatic logic [15:0] pick_map(input int i);
    if (i < NSINGLE) return 16'(1 << i);
    if (i == NSINGLE) return 16'hFFFF;
    return 16'((i - NSINGLE - 1) * 37 + 1);
  endfunction

  task automatic build();
    bit pl = 1'b1;
    logic [5:0] pc = '0;
    logic [7:0] pr = '0;
    for (int i = 0; i < NREC; i++) begin
      logic [5:0] col = 6'(i * 7 + 3);
      logic [7:0] row = 8'(i * 13 + 5);
      bit last = (i % 3 != 0);
      bit nbr  = (i % 4 == 1);
      logic [15:0] hm = pick_map(i);
      int k = 0;
      if (pl) begin push_bits({2'b0, col}, 6); pc = col; end
      push_bits({7'b0, last}, 1);
      push_bits({7'b0, nbr}, 1);
      if (nbr) pr = pr + 8'd1;
      else begin push_bits(row, 8); pr = row; end
      pl = last;
      e_col[i] = pc;
      e_row[i] = pr;
      e_map[i] = hm;
      e_tot[i] = '0;
      push_map(hm);
      for (int p = 0; p < 16; p++) if (hm[p]) begin
        logic [3:0] t = 4'(i + 3 * k + p);
        push_bits({4'b0, t}, 4);
        e_tot[i][k*4 +: 4] = t;
        k++;
      end
      e_hits[i] = 5'(k);
    end
    npk = (bq.size() + 62) / 63 + 3;
  endtask

  // R4: payload bit 62 first; bit 63 toggles and must have no effect
  function automatic logic [63:0] mk_pkt(input int pidx);
    logic [63:0] w;
    w[63] = pidx[0];
    for (int j = 0; j < 63; j++) begin
      int b = pidx * 63 + j;
      w[62 - j] = (b < bq.size()) ? bq[b] : 1'b0;
    end
    return w;
  endfunction

  task automatic send(input logic [63:0] p);
    in_valid = 1'b1;
    in_data  = p;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_driver();
    for (int pidx = 2; pidx < npk; pidx++) begin
      if (pidx % 7 == 3) repeat (3) @(negedge clk);
      send(mk_pkt(pidx));
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    chk(1'b0, "R7 watchdog expired", 64'(checks), 64'(0));
    summary();
    $finish;
  end

  initial begin
    int got = 0, cyc = 0, last_hs = -1;
    bit held = 1'b0, stall_ok = 1'b1;
    logic [5:0] s_col; logic [7:0] s_row; logic [15:0] s_map; logic [4:0] s_hits; logic [63:0] s_tot;
    build();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'(0));
    chk(in_ready == 1'b1, "R1 in_ready after reset", 64'(in_ready), 64'(1));
    send(mk_pkt(0));
    send(mk_pkt(1));
    for (int c = 0; c < 20; c++) begin
      if (out_valid) stall_ok = 1'b0;
      @(negedge clk);
    end
    chk(stall_ok, "R7 no record with two words loaded", 64'(!stall_ok), 64'(0));
    fork
      run_driver();
    join_none
    while (got < NREC) begin
      @(negedge clk);
      cyc++;
      out_ready = !((cyc % 7 == 2) || (cyc % 7 == 3));
      if (out_valid) begin
        if (held)
          chk({out_col, out_row, out_hitmap, out_hits} == {s_col, s_row, s_map, s_hits}
              && out_tot == s_tot, "R8 record held under stall",
              64'({out_col, out_row, out_hitmap}), 64'({s_col, s_row, s_map}));
        if (out_ready) begin
          chk(out_col == e_col[got], $sformatf("R2 R4 column rec %0d", got), 64'(out_col), 64'(e_col[got]));
          chk(out_row == e_row[got], $sformatf("R3 row rec %0d", got), 64'(out_row), 64'(e_row[got]));
          chk(out_hitmap == e_map[got], $sformatf("R5 hitmap rec %0d", got), 64'(out_hitmap), 64'(e_map[got]));
          chk(out_hits == e_hits[got], $sformatf("R6 hits rec %0d", got), 64'(out_hits), 64'(e_hits[got]));
          chk(out_tot == e_tot[got], $sformatf("R6 tot rec %0d", got), out_tot, e_tot[got]);
          if (last_hs >= 0)
            chk(cyc - last_hs >= 6, "R9 record spacing", 64'(cyc - last_hs), 64'(6));
          last_hs = cyc;
          got++;
          held = 1'b0;
        end else begin
          held = 1'b1;
          s_col = out_col; s_row = out_row; s_map = out_hitmap; s_hits = out_hits; s_tot = out_tot;
        end
      end
    end
    summary();
    $finish;
  end
endmodule